// File: doc/BRIEF.md
# Extended Hamming 32-to-64 Encoder

This block takes a 32-bit message word and protects it with a rate one-half single-error-correcting, double-error-detecting code. The word is cut into eight 4-bit groups. Each group gets three Hamming check bits and one overall check bit, which makes an 8-bit codeword. The eight codewords are packed side by side into a 64-bit result.

Both sides use a valid/ready handshake. The encoding logic is purely combinational and feeds a single output register. That register holds its word until the downstream side takes it. When the register is full and the consumer stalls, the block stops accepting input. When the register drains and refills in the same cycle, the block sustains one word per clock.

Top module: `hamx_enc32`

## Requirements
- R1: Input group k (in_data bits 4k+3..4k) is encoded into output byte k (out_data bits 8k+7..8k), for k from 0 to 7. In each group, message bit m1 is input bit 4k+3, m2 is 4k+2, m3 is 4k+1 and m4 is 4k.
- R2: In each output byte, bit 7 is c1 = m1^m3^m4, bit 6 is c2 = m1^m2^m3, and bit 5 is c3 = m2^m3^m4.
- R3: Bit 0 of each output byte is the XOR of that byte's bits 7..1, so every output byte has even parity.
- R4: Bits 4, 3, 2 and 1 of each output byte carry m1, m2, m3 and m4 unchanged.
- R5: A word is accepted on a rising edge where in_valid and in_ready are both 1. Its encoding is on out_data with out_valid at 1 after that same edge, which is one clock later.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change at the next edge.
- R7: in_ready is 0 whenever out_valid is 1 and out_ready is 0, so a held word is never overwritten.
- R8: A synchronous active-high rst clears out_valid. in_ready is 0 while rst is 1 and is 1 in the first cycle after reset.
- R9: When out_valid and out_ready are both 1, in_ready is 1. A handoff and a new acceptance can then share one edge, and back-to-back words flow at one per clock in their input order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Message word on in_data is offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 32 | Message word, eight 4-bit groups |
| out_valid | output | 1 | out_data holds an encoded word |
| out_ready | input | 1 | Consumer takes out_data this cycle |
| out_data | output | 64 | Eight packed 8-bit codewords |

## Verification
Two events can fall on the same edge: the held word is handed downstream, and a new word is accepted into the register it frees. This is provoked by streaming words back to back while out_ready is held high, and again while out_ready toggles or follows a pseudo-random pattern. The result is judged by a scoreboard. Every accepted word must come out exactly once, in order, with the bench's own bitwise encoding. Wherever the register is full and out_ready is high, in_ready must be high.

// File: rtl/hamx_pkg.sv
package hamx_pkg;

    localparam int MSG_W = 4;
    localparam int CW_W  = 8;

    typedef struct packed {
        logic m1;
        logic m2;
        logic m3;
        logic m4;
    } hamx_msg_t;

    typedef struct packed {
        logic      c1;
        logic      c2;
        logic      c3;
        hamx_msg_t msg;
        logic      pall;
    } hamx_cw_t;

    function automatic hamx_cw_t hamx_encode(input hamx_msg_t m);
        hamx_cw_t w;
        w.c1   = m.m1 ^ m.m3 ^ m.m4;
        w.c2   = m.m1 ^ m.m2 ^ m.m3;
        w.c3   = m.m2 ^ m.m3 ^ m.m4;
        w.msg  = m;
        w.pall = w.c1 ^ w.c2 ^ w.c3 ^ m.m1 ^ m.m2 ^ m.m3 ^ m.m4;
        return w;
    endfunction

endpackage

// File: rtl/hamx_nibble_enc.sv
module hamx_nibble_enc
    import hamx_pkg::*;
(
    input  hamx_msg_t msg,
    output hamx_cw_t  cw
);

    always_comb begin
        cw = hamx_encode(msg);
    end

endmodule

// File: rtl/hamx_out_stage.sv
module hamx_out_stage #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] d,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] q
);

    logic take;

    // Refill is allowed when empty or when the held word leaves this cycle.
    assign in_ready = !rst && (!out_valid || out_ready);
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else if (take) begin
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            q <= d;
        end
    end

endmodule

// File: rtl/hamx_enc32.sv
module hamx_enc32
    import hamx_pkg::*;
#(
    parameter int NIBBLES = 8,
    localparam int IN_W   = NIBBLES * MSG_W,
    localparam int OUT_W  = NIBBLES * CW_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data
);

    logic [OUT_W-1:0] coded;

    for (genvar k = 0; k < NIBBLES; k++) begin : g_grp
        hamx_msg_t m;
        hamx_cw_t  c;
        assign m = hamx_msg_t'(in_data[k*MSG_W +: MSG_W]);
        hamx_nibble_enc u_enc (
            .msg (m),
            .cw  (c)
        );
        assign coded[k*CW_W +: CW_W] = c;
    end

    hamx_out_stage #(
        .WIDTH (OUT_W)
    ) u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .d         (coded),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .q         (out_data)
    );

endmodule

// File: rtl/hamx_enc32_chk.sv
module hamx_enc32_chk #(
    parameter int NIBBLES = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [NIBBLES*8-1:0] out_data
);

    AST_RST_CLEARS: assert property (@(posedge clk) rst |=> !out_valid); // R8

    AST_RDY_IN_RST: assert property (@(posedge clk) rst |-> !in_ready); // R8

    AST_ACCEPT_LAT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid); // R5

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready); // R7

    AST_DRAIN_REFILL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |-> in_ready); // R9

    for (genvar k = 0; k < NIBBLES; k++) begin : g_par
        AST_EVEN_BYTE: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (^out_data[k*8 +: 8] == 1'b0)); // R3
    end

endmodule

bind hamx_enc32 hamx_enc32_chk #(
    .NIBBLES (NIBBLES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/hamx_enc32_test.sv
`timescale 1ns/1ps
module hamx_enc32_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_data;
    logic        out_valid;
    logic        out_ready;
    logic [63:0] out_data;

    int vectors  = 0;
    int failures = 0;
    int rmode    = 0;
    bit done     = 1'b0;
    logic [63:0] sb_q[$];
    logic [15:0] rlfsr = 16'hACE1;

    always #5 clk = ~clk;

    hamx_enc32 uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    // Reference: R1 group placement, R2 check bits, R4 message bits, R3 even parity
    function automatic logic [63:0] ref_code(input logic [31:0] w);
        logic [63:0] r = '0;
        for (int k = 0; k < 8; k++) begin
            logic a, b, c, d, x1, x2, x3;
            a  = w[4*k+3];
            b  = w[4*k+2];
            c  = w[4*k+1];
            d  = w[4*k];
            x1 = a ^ c ^ d;
            x2 = a ^ b ^ c;
            x3 = b ^ c ^ d;
            r[8*k+7] = x1;
            r[8*k+6] = x2;
            r[8*k+5] = x3;
            r[8*k+4] = a;
            r[8*k+3] = b;
            r[8*k+2] = c;
            r[8*k+1] = d;
            r[8*k]   = x1 ^ x2 ^ x3 ^ a ^ b ^ c ^ d;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: offer one word, push its expected encoding when accepted
    task automatic send(input logic [31:0] w);
        in_valid = 1'b1;
        in_data  = w;
        forever begin
            @(negedge clk);
            if (in_ready) break;
            @(posedge clk); #2;
        end
        sb_q.push_back(ref_code(w));
        @(posedge clk); #2;
        in_valid = 1'b0;
        in_data  = 'x;
    endtask

    // Consumer pattern: 0 always ready, 1 toggle, 2 pseudo-random, 3 long stall
    int stall_cnt = 0;
    always @(posedge clk) begin
        #1;
        rlfsr = {rlfsr[14:0], rlfsr[15] ^ rlfsr[13] ^ rlfsr[12] ^ rlfsr[10]};
        stall_cnt++;
        case (rmode)
            0: out_ready = 1'b1;
            1: out_ready = ~out_ready;
            2: out_ready = rlfsr[0];
            default: out_ready = (stall_cnt % 12) == 0;
        endcase
    end

    // Monitor / scoreboard, sampled at the falling edge
    logic        prev_stall = 1'b0;
    logic [63:0] prev_data  = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall)      // R6 held word stays
                check(out_valid && out_data == prev_data, "R6", out_data, prev_data);
            if (out_valid && !out_ready)  // R7
                check(!in_ready, "R7", {63'd0, in_ready}, 64'd0);
            if (out_valid && out_ready) begin
                check(in_ready, "R9", {63'd0, in_ready}, 64'd1);
                if (sb_q.size() == 0) begin
                    check(1'b0, "R5 unexpected word", out_data, 64'd0);
                end else begin
                    logic [63:0] e;
                    e = sb_q.pop_front();
                    check(out_data == e, "R1 R2 R3 R4 R9", out_data, e);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end else begin
            prev_stall = 1'b0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        rst = 1'b1;
        in_valid = 1'b0;
        in_data = '0;
        out_ready = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        @(negedge clk);
        check(!out_valid, "R8 out_valid in reset", {63'd0, out_valid}, 64'd0);
        check(!in_ready, "R8 in_ready in reset", {63'd0, in_ready}, 64'd0);
        @(posedge clk); #2;
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid, "R8 out_valid after reset", {63'd0, out_valid}, 64'd0);
        check(in_ready, "R8 in_ready after reset", {63'd0, in_ready}, 64'd1);

        // R5 latency: word accepted at an edge is valid right after it
        @(posedge clk); #2;
        rmode = 3;
        in_valid = 1'b1;
        in_data = 32'h0000_0001;
        @(negedge clk);
        sb_q.push_back(ref_code(32'h0000_0001));
        @(posedge clk); #2;
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid, "R5", {63'd0, out_valid}, 64'd1);
        // R1 group 0 value 1: expected byte 0 = A3, other bytes zero
        check(out_data == 64'h0000_0000_0000_00A3, "R1", out_data, 64'h0000_0000_0000_00A3);

        // Corner patterns under various consumer patterns
        for (int md = 0; md < 4; md++) begin
            rmode = md;
            send(32'h0000_0000);
            send(32'hFFFF_FFFF);
            send(32'h1234_5678);
            send(32'hA5A5_A5A5);
            for (int k = 0; k < 8; k++) send(32'h8 << (4 * k)); // R1 m1 alone
            seed = 32'h1357_9BDF + md;
            for (int i = 0; i < 40; i++) begin
                seed = seed * 32'd1664525 + 32'd1013904223;
                send(seed);
            end
        end

        // R9 streaming with consumer always ready
        rmode = 0;
        for (int i = 0; i < 16; i++) send(32'h0F0F_0000 + i);

        repeat (100) @(posedge clk);
        check(sb_q.size() == 0, "R5 all words delivered", 64'(sb_q.size()), 64'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
        $finish;
    end

endmodule